// File: doc/BRIEF.md
# Passive Serial FPGA Configuration Master

This block loads a configuration image into a target FPGA over a passive-serial link. A single-cycle start pulse begins a timed handshake with the target. The block first checks that the target's status line reads high. It then drives the configuration-request pin low until the status line acknowledges, and releases it. It waits for the status line to return high and holds a minimum gap before the first serial clock. After that it streams the image bytes from a valid/ready byte interface onto the data pin, least significant bit first.

When the last image byte has been shifted, the block checks the status line again. If the build includes a configuration-done input, it waits for that input to rise. It then sends one dummy byte of eight serial clocks so the target can enter user mode. Every wait is a deadline in system clock cycles. Within the deadline the pin is polled at a fixed period. Each failure point has its own error code, held until the next start.

All limits are parameters: the serial clock half period, the poll period, the acknowledge window, the ready deadline, the status-to-clock gap, the done deadline, the synchronizer depth and whether the done input exists.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset, nconfig is 1, dclk is 0, data0 is 0, busy is 0, done is 0, and err_code is 0.
- R2: If the synchronized status input is low when a start is taken, the block ends with err_code 1 and never drives nconfig low.
- R3: The block drives nconfig low until the status input is seen low. If the status input is not seen low within T_ACK_CYC cycles, it ends with err_code 2.
- R4: After the acknowledge, nconfig returns high. If the status input is not seen high within T_RDY_CYC cycles, the block ends with err_code 3.
- R5: Pins are polled once every POLL_CYC cycles. At least one sample is taken even when a deadline is shorter than the poll period.
- R6: At least T_ST2CK_CYC cycles pass between the status input going high and the first rising edge of dclk.
- R7: Each image byte is sent on data0 least significant bit first. data0 changes only when dclk falls and is stable while dclk is high. Each dclk phase lasts CLK_HALF_CYC cycles.
- R8: While the byte stream has no valid byte, dclk stays low. Streaming resumes with no bit lost or repeated. in_last marks the final image byte.
- R9: If the status input is low after the last image bit, the block ends with err_code 4 and sends no trailing clocks.
- R10: With HAS_DONE_PIN=1, conf_done must rise within T_DONE_CYC cycles after the last byte, or the block ends with err_code 5. With HAS_DONE_PIN=0, this check is skipped.
- R11: On success, the block sends one dummy byte of eight dclk cycles with data0 at 0, then raises done with err_code 0.
- R12: A start pulse while busy is ignored. done and err_code are cleared by a start taken while idle and are otherwise held. When idle, nconfig is 1 and dclk is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle request to begin a load |
| in_valid | input | 1 | Image byte valid |
| in_data | input | 8 | Image byte |
| in_last | input | 1 | Marks the final image byte |
| in_ready | output | 1 | Block accepts the offered byte |
| nstatus | input | 1 | Target status line, asynchronous |
| conf_done | input | 1 | Target configuration-done line, asynchronous |
| nconfig | output | 1 | Configuration request to the target, low requests reset |
| dclk | output | 1 | Serial configuration clock |
| data0 | output | 1 | Serial configuration data |
| busy | output | 1 | A load sequence is in progress |
| done | output | 1 | Last load succeeded |
| err_code | output | 3 | 0 none, 1 initial status, 2 no acknowledge, 3 not ready, 4 configuration error, 5 done timeout |

## Verification
The assertions assume the status input is a level that the target holds for many cycles at a time. They also assume conf_done, once raised, stays high until the next load. The status-to-clock gap check counts raw high cycles of the status input, so it relies on the target not toggling that line during loading. The bench drives a behavioural target model that follows these rules and only breaks one of them on purpose when a fault case calls for it. It also feeds bytes with randomly chosen idle gaps, so stalls land on every byte boundary.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

   typedef enum logic [2:0] {
      ERR_NONE    = 3'd0,
      ERR_INIT    = 3'd1,
      ERR_NOACK   = 3'd2,
      ERR_NOTRDY  = 3'd3,
      ERR_CFG     = 3'd4,
      ERR_DONE_TO = 3'd5
   } ps_err_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_CHK_INIT,
      S_RST,
      S_RDY,
      S_GAP,
      S_LOAD,
      S_SETTLE,
      S_DONE_WAIT,
      S_TRAIL
   } ps_state_e;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/ps_pin_sync.sv
module ps_pin_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   logic [STAGES-1:0] q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[0] <= RST_VAL;
            else        q[0] <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= {STAGES{RST_VAL}};
            else        q <= {q[STAGES-2:0], din};
         end
      end
   endgenerate

   assign dout = q[STAGES-1];

endmodule

// File: rtl/ps_level_wait.sv
module ps_level_wait #(
   parameter int POLL_CYC = 4,
   parameter int CW       = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          goal,
   input  logic [CW-1:0] limit,
   input  logic          pin,
   output logic          hit,
   output logic          miss
);

   localparam int PW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;

   logic          active;
   logic [PW-1:0] pc;
   logic [CW-1:0] tot;
   logic          poll_now;

   assign poll_now = active && (pc == PW'(POLL_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         pc     <= '0;
         tot    <= '0;
         hit    <= 1'b0;
         miss   <= 1'b0;
      end else begin
         hit  <= 1'b0;
         miss <= 1'b0;
         if (go) begin
            active <= 1'b1;
            pc     <= '0;
            tot    <= '0;
         end else if (active) begin
            tot <= tot + CW'(1);
            if (poll_now) begin
               pc <= '0;
               if (pin == goal) begin
                  hit    <= 1'b1;
                  active <= 1'b0;
               end else if (tot + CW'(1) >= limit) begin
                  miss   <= 1'b1;
                  active <= 1'b0;
               end
            end else begin
               pc <= pc + PW'(1);
            end
         end
      end
   end

endmodule

// File: rtl/ps_bit_shifter.sv
module ps_bit_shifter #(
   parameter int HALF_CYC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld_valid,
   input  logic [7:0] ld_data,
   input  logic       ld_last,
   output logic       ld_ready,
   output logic       dclk,
   output logic       data0,
   output logic       byte_end,
   output logic       byte_last
);

   localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

   logic          full;
   logic [7:0]    sh;
   logic [2:0]    nbit;
   logic          lastf;
   logic          clk_q;
   logic [DW-1:0] dv;
   logic          phase_end;

   assign phase_end = (dv == DW'(HALF_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full      <= 1'b0;
         sh        <= '0;
         nbit      <= '0;
         lastf     <= 1'b0;
         clk_q     <= 1'b0;
         dv        <= '0;
         byte_end  <= 1'b0;
         byte_last <= 1'b0;
      end else begin
         byte_end  <= 1'b0;
         byte_last <= 1'b0;
         if (!full) begin
            if (ld_valid) begin
               full  <= 1'b1;
               sh    <= ld_data;
               nbit  <= '0;
               lastf <= ld_last;
               dv    <= '0;
            end
         end else if (phase_end) begin
            dv <= '0;
            if (!clk_q) begin
               clk_q <= 1'b1;
            end else begin
               clk_q <= 1'b0;
               sh    <= {1'b0, sh[7:1]};
               nbit  <= nbit + 3'd1;
               if (nbit == 3'd7) begin
                  full      <= 1'b0;
                  byte_end  <= 1'b1;
                  byte_last <= lastf;
               end
            end
         end else begin
            dv <= dv + DW'(1);
         end
      end
   end

   assign ld_ready = !full;
   assign dclk     = clk_q;
   assign data0    = sh[0];

endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
   import ps_cfg_pkg::*;
#(
   parameter int CLK_HALF_CYC = 2,
   parameter int POLL_CYC     = 1000,
   parameter int T_ACK_CYC    = 200,
   parameter int T_RDY_CYC    = 23000,
   parameter int T_ST2CK_CYC  = 200,
   parameter int T_DONE_CYC   = 50000,
   parameter int SYNC_STAGES  = 2,
   parameter int HAS_DONE_PIN = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       in_valid,
   input  logic [7:0] in_data,
   input  logic       in_last,
   output logic       in_ready,
   input  logic       nstatus,
   input  logic       conf_done,
   output logic       nconfig,
   output logic       dclk,
   output logic       data0,
   output logic       busy,
   output logic       done,
   output logic [2:0] err_code
);

   localparam int LIM_MAX = max4(T_ACK_CYC, T_RDY_CYC, T_DONE_CYC,
                                 T_ST2CK_CYC + SYNC_STAGES);
   localparam int CW      = $clog2(LIM_MAX + 2) + 1;

   generate
      if (CLK_HALF_CYC < 1 || POLL_CYC < 1 || T_ST2CK_CYC < 1 ||
          SYNC_STAGES < 1 || T_ACK_CYC < 1 || T_RDY_CYC < 1 || T_DONE_CYC < 1) begin : g_bad_cfg
         $error("ps_cfg_master: timing parameters must all be at least 1");
      end
      if (HAS_DONE_PIN != 0 && HAS_DONE_PIN != 1) begin : g_bad_done
         $error("ps_cfg_master: HAS_DONE_PIN must be 0 or 1");
      end
   endgenerate

   ps_state_e     st;
   ps_err_e       err_q;
   logic          done_q;
   logic          got_last;
   logic          trail_sent;
   logic [CW-1:0] tcnt;
   logic          wgo;

   logic          nst_s;
   logic          cd_s;

   logic          w_goal;
   logic [CW-1:0] w_lim;
   logic          w_pin;
   logic          w_hit;
   logic          w_miss;

   logic          sh_valid;
   logic [7:0]    sh_data;
   logic          sh_last;
   logic          sh_ready;
   logic          sh_take;
   logic          b_end;
   logic          b_last;
   logic          last_end;

   // pin synchronizers; the done input exists only when the build asks for it
   ps_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_nst (
      .clk (clk), .rst_n (rst_n), .din (nstatus), .dout (nst_s)
   );

   generate
      if (HAS_DONE_PIN != 0) begin : g_done_pin
         ps_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_cd (
            .clk (clk), .rst_n (rst_n), .din (conf_done), .dout (cd_s)
         );
      end else begin : g_no_done_pin
         assign cd_s = 1'b1;
      end
   endgenerate

   // one poller serves all three deadline waits
   always_comb begin
      case (st)
         S_RST: begin
            w_goal = 1'b0;
            w_lim  = CW'(T_ACK_CYC);
            w_pin  = nst_s;
         end
         S_DONE_WAIT: begin
            w_goal = 1'b1;
            w_lim  = CW'(T_DONE_CYC);
            w_pin  = cd_s;
         end
         default: begin
            w_goal = 1'b1;
            w_lim  = CW'(T_RDY_CYC);
            w_pin  = nst_s;
         end
      endcase
   end

   ps_level_wait #(.POLL_CYC(POLL_CYC), .CW(CW)) u_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (wgo),
      .goal  (w_goal),
      .limit (w_lim),
      .pin   (w_pin),
      .hit   (w_hit),
      .miss  (w_miss)
   );

   // shifter feed: image bytes while loading, one zero byte while trailing
   assign sh_valid = ((st == S_LOAD) && in_valid && !got_last) ||
                     ((st == S_TRAIL) && !trail_sent);
   assign sh_data  = (st == S_TRAIL) ? 8'h00 : in_data;
   assign sh_last  = (st == S_TRAIL) ? 1'b1  : in_last;
   assign sh_take  = sh_valid && sh_ready;
   assign in_ready = (st == S_LOAD) && !got_last && sh_ready;
   assign last_end = b_end && b_last;

   ps_bit_shifter #(.HALF_CYC(CLK_HALF_CYC)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_valid  (sh_valid),
      .ld_data   (sh_data),
      .ld_last   (sh_last),
      .ld_ready  (sh_ready),
      .dclk      (dclk),
      .data0     (data0),
      .byte_end  (b_end),
      .byte_last (b_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         err_q      <= ERR_NONE;
         done_q     <= 1'b0;
         got_last   <= 1'b0;
         trail_sent <= 1'b0;
         tcnt       <= '0;
         wgo        <= 1'b0;
      end else begin
         wgo <= 1'b0;
         case (st)
            S_IDLE: begin
               if (start) begin
                  st         <= S_CHK_INIT;
                  err_q      <= ERR_NONE;
                  done_q     <= 1'b0;
                  got_last   <= 1'b0;
                  trail_sent <= 1'b0;
               end
            end
            S_CHK_INIT: begin
               if (!nst_s) begin
                  err_q <= ERR_INIT;
                  st    <= S_IDLE;
               end else begin
                  st  <= S_RST;
                  wgo <= 1'b1;
               end
            end
            S_RST: begin
               if (w_hit) begin
                  st  <= S_RDY;
                  wgo <= 1'b1;
               end else if (w_miss) begin
                  err_q <= ERR_NOACK;
                  st    <= S_IDLE;
               end
            end
            S_RDY: begin
               if (w_hit) begin
                  st   <= S_GAP;
                  tcnt <= '0;
               end else if (w_miss) begin
                  err_q <= ERR_NOTRDY;
                  st    <= S_IDLE;
               end
            end
            S_GAP: begin
               if (tcnt == CW'(T_ST2CK_CYC - 1)) st <= S_LOAD;
               else                             tcnt <= tcnt + CW'(1);
            end
            S_LOAD: begin
               if (sh_take && in_last) got_last <= 1'b1;
               if (last_end) begin
                  st   <= S_SETTLE;
                  tcnt <= '0;
               end
            end
            S_SETTLE: begin
               // let the status pin pass the synchronizer before judging it
               if (tcnt == CW'(SYNC_STAGES)) begin
                  if (!nst_s) begin
                     err_q <= ERR_CFG;
                     st    <= S_IDLE;
                  end else if (HAS_DONE_PIN != 0) begin
                     st  <= S_DONE_WAIT;
                     wgo <= 1'b1;
                  end else begin
                     st <= S_TRAIL;
                  end
               end else begin
                  tcnt <= tcnt + CW'(1);
               end
            end
            S_DONE_WAIT: begin
               if (w_hit) begin
                  st <= S_TRAIL;
               end else if (w_miss) begin
                  err_q <= ERR_DONE_TO;
                  st    <= S_IDLE;
               end
            end
            S_TRAIL: begin
               if (sh_take) trail_sent <= 1'b1;
               if (last_end) begin
                  done_q <= 1'b1;
                  st     <= S_IDLE;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign nconfig  = (st != S_RST);
   assign busy     = (st != S_IDLE);
   assign done     = done_q;
   assign err_code = err_q;

endmodule

// File: rtl/ps_cfg_master_chk.sv
module ps_cfg_master_chk #(
   parameter int T_ST2CK_CYC  = 200,
   parameter int HAS_DONE_PIN = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       in_valid,
   input logic       in_ready,
   input logic       nstatus,
   input logic       conf_done,
   input logic       nconfig,
   input logic       dclk,
   input logic       data0,
   input logic       busy,
   input logic       done,
   input logic [2:0] err_code
);

   logic [15:0] nst_hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  nst_hi_cnt <= '0;
      else if (!nstatus)           nst_hi_cnt <= '0;
      else if (nst_hi_cnt != '1)   nst_hi_cnt <= nst_hi_cnt + 16'd1;
   end

   assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dclk && $past(dclk)) |-> $stable(data0));

   assert_status_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dclk) |-> (nst_hi_cnt >= 16'(T_ST2CK_CYC)));

   assert_stall_clock_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> !dclk);

   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!dclk && nconfig));

   assert_start_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done && err_code == 3'd0));

   assert_done_needs_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((HAS_DONE_PIN != 0) && $rose(done)) |-> conf_done);

   assert_err_excludes_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_code != 3'd0) |-> !done);

endmodule

bind ps_cfg_master ps_cfg_master_chk #(
   .T_ST2CK_CYC  (T_ST2CK_CYC),
   .HAS_DONE_PIN (HAS_DONE_PIN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .nstatus   (nstatus),
   .conf_done (conf_done),
   .nconfig   (nconfig),
   .dclk      (dclk),
   .data0     (data0),
   .busy      (busy),
   .done      (done),
   .err_code  (err_code)
);

// File: tb/test_ps_cfg_master.sv
`timescale 1ns/1ps
module test_ps_cfg_master;

   localparam int HALF   = 2;
   localparam int POLL   = 4;
   localparam int T_ACK  = 8;
   localparam int T_RDY  = 40;
   localparam int T_GAP  = 6;
   localparam int T_DONE = 40;
   localparam int RDY_DLY  = 10;
   localparam int DONE_DLY = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_last = 1'b0;
   logic       nstatus = 1'b1;
   logic       conf_done = 1'b0;

   logic       in_ready1, nconfig1, dclk1, data01, busy1, done1;
   logic [2:0] err1;
   logic       in_ready2, nconfig2, dclk2, data02, busy2, done2;
   logic [2:0] err2;

   always #2.5 clk = ~clk;

   ps_cfg_master #(
      .CLK_HALF_CYC(HALF), .POLL_CYC(POLL), .T_ACK_CYC(T_ACK), .T_RDY_CYC(T_RDY),
      .T_ST2CK_CYC(T_GAP), .T_DONE_CYC(T_DONE), .SYNC_STAGES(2), .HAS_DONE_PIN(1)
   ) i_ps_cfg_master (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .in_ready(in_ready1), .nstatus(nstatus), .conf_done(conf_done),
      .nconfig(nconfig1), .dclk(dclk1), .data0(data01), .busy(busy1), .done(done1),
      .err_code(err1)
   );

   // variant: acknowledge window shorter than the poll period, no done input
   ps_cfg_master #(
      .CLK_HALF_CYC(HALF), .POLL_CYC(POLL), .T_ACK_CYC(2), .T_RDY_CYC(T_RDY),
      .T_ST2CK_CYC(T_GAP), .T_DONE_CYC(T_DONE), .SYNC_STAGES(2), .HAS_DONE_PIN(0)
   ) i_ps_cfg_master_nd (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .in_ready(in_ready2), .nstatus(nstatus), .conf_done(conf_done),
      .nconfig(nconfig2), .dclk(dclk2), .data0(data02), .busy(busy2), .done(done2),
      .err_code(err2)
   );

   int nchk = 0;
   int nfail = 0;

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // target model state
   bit   ack_en, rdy_en, cfg_fail, done_en, hold_low;
   int   exp_len;
   int   rcnt, dcnt;
   int   nb;
   logic cap [0:127];
   int   cyc = 0;
   int   t_rise, first_rise;
   int   ncfg_falls;
   logic [7:0] img [0:7];

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge nconfig1) ncfg_falls++;

   always @(posedge dclk1) begin
      if (nb == 0) first_rise = cyc;
      if (nb < 128) cap[nb] = data01;
      nb++;
   end

   always @(negedge clk) begin
      if (!hold_low) begin
         if (!nconfig1) begin
            rcnt = 0;
            if (ack_en) nstatus = 1'b0;
         end else if (!nstatus) begin
            if (rdy_en) begin
               if (rcnt == RDY_DLY) begin
                  nstatus = 1'b1;
                  t_rise  = cyc;
               end else begin
                  rcnt++;
               end
            end
         end
         if (cfg_fail && exp_len > 0 && nb == 8 * exp_len) begin
            nstatus  = 1'b0;
            hold_low = 1'b1;
         end
      end
      if (done_en && exp_len > 0 && nb >= 8 * exp_len) begin
         if (dcnt == DONE_DLY) conf_done = 1'b1;
         else dcnt++;
      end
   end

   task automatic send_image(input int len, input bit gaps, input bit poke);
      for (int k = 0; k < len; k++) begin
         if (gaps) repeat ($urandom_range(0, 3)) @(negedge clk);
         in_valid = 1'b1;
         in_data  = img[k];
         in_last  = (k == len - 1);
         while (!in_ready1) @(negedge clk);
         @(negedge clk);
         in_valid = 1'b0;
         in_last  = 1'b0;
         if (poke && k == 0) begin
            start = 1'b1;       // R12: start while busy must be ignored
            @(negedge clk);
            start = 1'b0;
         end
      end
   endtask

   // mode: 0 success, 1 bad initial status, 2 no ack, 3 never ready, 4 status low at end, 5 done timeout
   task automatic run_case(input int len, input int mode, input bit gaps, input bit poke);
      int exp_bits;
      int mism;
      ack_en   = (mode != 2);
      rdy_en   = (mode != 3);
      cfg_fail = (mode == 4);
      done_en  = (mode != 5);
      exp_len  = len;
      rcnt = 0; dcnt = 0; nb = 0;
      first_rise = -1; t_rise = cyc;
      conf_done = 1'b0;
      hold_low  = 1'b0;
      nstatus   = 1'b1;
      if (mode == 1) begin
         hold_low = 1'b1;
         nstatus  = 1'b0;
      end
      for (int k = 0; k < 8; k++) img[k] = 8'($urandom);
      repeat (5) @(negedge clk);
      ncfg_falls = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (mode == 0 || mode == 4 || mode == 5) send_image(len, gaps, poke);
      while (busy1 || busy2) @(negedge clk);
      repeat (2) @(negedge clk);

      exp_bits = (mode == 0) ? 8 * len + 8 : ((mode == 4 || mode == 5) ? 8 * len : 0);
      mism = 0;
      for (int i = 0; i < exp_bits && i < 128; i++) begin
         if (cap[i] !== ((i < 8 * len) ? img[i / 8][i % 8] : 1'b0)) mism++;
      end
      case (mode)
         0: begin
            chk("R11 done flag", done1, 1);
            chk("R11 err after success", err1, 0);
            chk("R11 bit count incl dummy byte", nb, exp_bits);
            chk(gaps ? "R8 bits with stalls" : "R7 lsb-first bits", mism, 0);
            chk("R6 status-to-clock gap ok", int'((first_rise - t_rise) >= T_GAP), 1);
            chk("R5 short window still sampled", done2, 1);
         end
         1: begin
            chk("R2 init error code", err1, 1);
            chk("R2 nconfig never pulsed", ncfg_falls, 0);
            chk("R2 no clocks", nb, 0);
         end
         2: begin
            chk("R3 no ack code", err1, 2);
            chk("R3 no ack code short window", err2, 2);
         end
         3: begin
            chk("R4 not ready code", err1, 3);
            chk("R4 not ready code variant", err2, 3);
         end
         4: begin
            chk("R9 config error code", err1, 4);
            chk("R9 no trailing clocks", nb, exp_bits);
            chk("R9 image bits before error", mism, 0);
            chk("R9 variant code", err2, 4);
         end
         default: begin
            chk("R10 done timeout code", err1, 5);
            chk("R10 no trailing clocks", nb, exp_bits);
            chk("R10 skipped without pin", done2, 1);
            chk("R10 variant err", err2, 0);
         end
      endcase
   endtask

   initial begin
      void'($urandom(32'h5eed_0c0f));
      repeat (4) @(negedge clk);
      // R1 reset values, sampled while reset is still applied
      chk("R1 nconfig", nconfig1, 1);
      chk("R1 dclk", dclk1, 0);
      chk("R1 data0", data01, 0);
      chk("R1 busy", busy1, 0);
      chk("R1 done", done1, 0);
      chk("R1 err", err1, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      run_case(1, 0, 1'b0, 1'b0);
      run_case(4, 0, 1'b0, 1'b0);
      for (int r = 0; r < 6; r++) run_case($urandom_range(1, 8), 0, 1'b1, 1'b0);

      run_case(3, 0, 1'b1, 1'b1);
      chk("R12 start while busy ignored", done1, 1);
      repeat (20) @(negedge clk);
      chk("R12 done held", done1, 1);
      chk("R12 idle nconfig high", nconfig1, 1);
      chk("R12 idle dclk low", dclk1, 0);

      run_case(2, 1, 1'b0, 1'b0);
      repeat (20) @(negedge clk);
      chk("R12 error held", err1, 1);
      run_case(2, 2, 1'b0, 1'b0);
      run_case(2, 3, 1'b0, 1'b0);
      run_case(3, 4, 1'b1, 1'b0);
      run_case(2, 5, 1'b0, 1'b0);
      run_case(5, 0, 1'b1, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule